// File: doc/BRIEF.md
# Instruction-Sequenced Pipelined Memory Module

This block is a data memory that never receives addresses at run time. A host first fills a small local program table through a load port. Each table entry is an elementary memory instruction made of a data address and a read/write flag. A start command then names the first table index, the number of entries to execute and a repeat count. From that point the sequencer issues one instruction per clock cycle into a data array that is pipelined in three registered stages.

The address stream is fixed before the run begins, so the data path never waits and never stalls. Write data is taken from an input port in the cycle its instruction issues. Read data appears on an output port a fixed number of cycles later, marked by a strobe. The table can hold several independent programs at once, and the start index chooses which one runs. A loaded program can be executed any number of times before the host replaces it.

Top module: `iseq_mem_module`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done`, `rvalid` and `ld_err` are low and `rdata` is zero.
- R2: When `busy` is low, a load with `ld_en` high stores the address `ld_addr` and the flag `ld_wr` (1 = write, 0 = read) at table index `ld_idx`. A later run executes that entry.
- R3: A read instruction issued in cycle k raises `rvalid` for exactly one cycle, in cycle k+3. Write instructions never raise `rvalid`.
- R4: A write instruction stores the `wdata` value present in its issue cycle. A read issued later returns the most recent value written to that address, including a write issued in the cycle just before.
- R5: A start command that is accepted in cycle k issues table entries start, start+1, ... in cycles k+1, k+2, ..., one per cycle. It issues `go_len` entries per pass, and the index wraps modulo the table depth. `busy` is high in exactly the issue cycles.
- R6: `done` is high for exactly one cycle, in the cycle after the last issued instruction, and `busy` is low in that cycle.
- R7: A start command with `go_len` of zero is ignored. A start command that arrives while `busy` is high is also ignored.
- R8: A load that arrives while `busy` is high leaves the table unchanged. It raises `ld_err` for one cycle, in the cycle after the load.
- R9: A repeat count of r gives r+1 passes over the same entries, back to back, with no idle cycle between passes.
- R10: In the default configuration, `rdata` is zero in every cycle in which `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Table load strobe |
| ld_idx | input | SEQ_AW | Table index to load |
| ld_addr | input | DATA_AW | Data address of the loaded instruction |
| ld_wr | input | 1 | Instruction flag, 1 = write, 0 = read |
| go | input | 1 | Start command |
| go_start | input | SEQ_AW | First table index of the run |
| go_len | input | SEQ_AW+1 | Entries per pass, 1 to table depth |
| go_reps | input | REP_W | Additional passes after the first |
| wdata | input | DW | Write data for the instruction issued this cycle |
| busy | output | 1 | High in each issue cycle |
| done | output | 1 | One-cycle pulse after the last issue |
| ld_err | output | 1 | One-cycle pulse after a load that was refused |
| rdata | output | DW | Read data |
| rvalid | output | 1 | Read data strobe |

## Verification
If the sequencer pointer is wrong, the wrong table entry runs. This shows at the ports three cycles later, either as an `rvalid` strobe where none is expected or as a read value from the wrong address. A lost or misplaced write stays hidden until the next read of that address, so each test run mixes reads and writes on shared addresses. A bad pass or repeat counter shows one cycle after the wrong final issue, through the timing of `busy` and `done`. A table corrupted by a refused load only shows when a later run uses that entry, so the refused load always targets an entry that a later run uses.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
   typedef enum logic {
      OP_RD = 1'b0,
      OP_WR = 1'b1
   } mem_op_e;
endpackage

// File: rtl/iseq_store.sv
module iseq_store
   import iseq_pkg::*;
#(
   parameter int SEQ_AW  = 5,
   parameter int DATA_AW = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic               busy,
   input  logic [SEQ_AW-1:0]  ld_idx,
   input  logic [DATA_AW-1:0] ld_addr,
   input  mem_op_e            ld_op,
   input  logic [SEQ_AW-1:0]  rd_idx,
   output logic [DATA_AW-1:0] rd_addr,
   output mem_op_e            rd_op,
   output logic               ld_err
);
   localparam int DEPTH = 1 << SEQ_AW;
   localparam int EW    = DATA_AW + 1;

   logic [EW-1:0] tbl [DEPTH];
   logic          take;

   assign take = ld_en && !busy;

   always_ff @(posedge clk) begin
      if (take) tbl[ld_idx] <= {ld_op, ld_addr};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ld_err <= 1'b0;
      else        ld_err <= ld_en && busy;
   end

   assign rd_addr = tbl[rd_idx][DATA_AW-1:0];
   assign rd_op   = mem_op_e'(tbl[rd_idx][EW-1]);

   AST_ERR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ld_err |-> $past(busy)); // R8
endmodule

// File: rtl/iseq_sequencer.sv
module iseq_sequencer #(
   parameter int SEQ_AW = 5,
   parameter int REP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [SEQ_AW-1:0] go_start,
   input  logic [SEQ_AW:0]   go_len,
   input  logic [REP_W-1:0]  go_reps,
   output logic              busy,
   output logic              done,
   output logic [SEQ_AW-1:0] ptr
);
   localparam int LW = SEQ_AW + 1;
   localparam logic [LW-1:0]     L_ONE = LW'(1);
   localparam logic [SEQ_AW-1:0] P_ONE = SEQ_AW'(1);
   localparam logic [REP_W-1:0]  R_ONE = REP_W'(1);

   logic [SEQ_AW-1:0] start_q;
   logic [LW-1:0]     len_q;
   logic [LW-1:0]     cnt;
   logic [REP_W-1:0]  reps_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         ptr     <= '0;
         start_q <= '0;
         len_q   <= '0;
         cnt     <= '0;
         reps_q  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (go && go_len != '0) begin
               busy    <= 1'b1;
               ptr     <= go_start;
               start_q <= go_start;
               len_q   <= go_len;
               cnt     <= go_len - L_ONE;
               reps_q  <= go_reps;
            end
         end else if (cnt == '0) begin
            if (reps_q == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               reps_q <= reps_q - R_ONE;
               ptr    <= start_q;
               cnt    <= len_q - L_ONE;
            end
         end else begin
            ptr <= ptr + P_ONE;
            cnt <= cnt - L_ONE;
         end
      end
   end

   AST_CNT_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt < len_q); // R5
   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) && busy |-> (ptr == $past(ptr) + P_ONE) || (ptr == start_q)); // R9
endmodule

// File: rtl/iseq_data_array.sv
module iseq_data_array
   import iseq_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 6,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  mem_op_e       in_op,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_wdata,
   output logic          out_v,
   output logic [DW-1:0] out_data
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];
   logic          v1, wr1, v2, v3;
   logic [AW-1:0] a1;
   logic [DW-1:0] d1, rd2, rd3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         v3 <= 1'b0;
      end else begin
         v1 <= in_v;
         v2 <= v1 && !wr1;
         v3 <= v2;
      end
   end

   always_ff @(posedge clk) begin
      wr1 <= (in_op == OP_WR);
      a1  <= in_addr;
      d1  <= in_wdata;
      rd2 <= mem[a1];
      rd3 <= rd2;
      if (v1 && wr1) mem[a1] <= d1;
   end

   assign out_v = v3;

   generate
      if (ZERO_IDLE) begin : g_zero
         assign out_data = v3 ? rd3 : '0;
         AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !out_v |-> out_data == '0); // R10
      end else begin : g_hold
         assign out_data = rd3;
      end
   endgenerate
endmodule

// File: rtl/iseq_mem_module.sv
module iseq_mem_module
   import iseq_pkg::*;
#(
   parameter int DW        = 16,
   parameter int DATA_AW   = 6,
   parameter int SEQ_AW    = 5,
   parameter int REP_W     = 4,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [SEQ_AW-1:0]  ld_idx,
   input  logic [DATA_AW-1:0] ld_addr,
   input  logic               ld_wr,
   input  logic               go,
   input  logic [SEQ_AW-1:0]  go_start,
   input  logic [SEQ_AW:0]    go_len,
   input  logic [REP_W-1:0]   go_reps,
   input  logic [DW-1:0]      wdata,
   output logic               busy,
   output logic               done,
   output logic               ld_err,
   output logic [DW-1:0]      rdata,
   output logic               rvalid
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("data width must be at least 1");
      end
      if (DATA_AW < 1 || DATA_AW > 12) begin : g_bad_aw
         $error("data address width out of range");
      end
      if (SEQ_AW < 1 || SEQ_AW > 10) begin : g_bad_saw
         $error("table index width out of range");
      end
      if (REP_W < 1) begin : g_bad_rw
         $error("repeat width must be at least 1");
      end
   endgenerate

   logic [SEQ_AW-1:0]  ptr;
   logic [DATA_AW-1:0] iss_addr;
   mem_op_e            iss_op;

   iseq_store #(.SEQ_AW(SEQ_AW), .DATA_AW(DATA_AW)) i_store (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .busy(busy),
      .ld_idx(ld_idx), .ld_addr(ld_addr), .ld_op(mem_op_e'(ld_wr)),
      .rd_idx(ptr), .rd_addr(iss_addr), .rd_op(iss_op), .ld_err(ld_err)
   );

   iseq_sequencer #(.SEQ_AW(SEQ_AW), .REP_W(REP_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .go_start(go_start),
      .go_len(go_len), .go_reps(go_reps),
      .busy(busy), .done(done), .ptr(ptr)
   );

   iseq_data_array #(.DW(DW), .AW(DATA_AW), .ZERO_IDLE(ZERO_IDLE)) i_array (
      .clk(clk), .rst_n(rst_n), .in_v(busy), .in_op(iss_op),
      .in_addr(iss_addr), .in_wdata(wdata),
      .out_v(rvalid), .out_data(rdata)
   );

   AST_RVALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> $past(busy && iss_op == OP_RD, 3)); // R3
   AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy && iss_op == OP_RD, 3) |-> rvalid); // R3
   AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy)); // R6
endmodule

// File: tb/test_iseq_mem_module.sv
module test_iseq_mem_module;
   localparam int DW = 16, AW = 6, SAW = 5, RW = 4;
   localparam int DEPTH = 1 << SAW, WORDS = 1 << AW, MAXT = 1100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ld_en = 1'b0, ld_wr = 1'b0, go = 1'b0;
   logic [SAW-1:0] ld_idx = '0, go_start = '0;
   logic [AW-1:0]  ld_addr = '0;
   logic [SAW:0]   go_len = '0;
   logic [RW-1:0]  go_reps = '0;
   logic [DW-1:0]  wdata = '0;
   logic busy, done, ld_err, rvalid;
   logic [DW-1:0] rdata;

   always #5ns clk = ~clk;

   iseq_mem_module i_iseq_mem_module (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_addr(ld_addr), .ld_wr(ld_wr), .go(go), .go_start(go_start),
      .go_len(go_len), .go_reps(go_reps), .wdata(wdata),
      .busy(busy), .done(done), .ld_err(ld_err), .rdata(rdata), .rvalid(rvalid)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   logic [AW-1:0] m_addr [DEPTH];
   bit            m_wr   [DEPTH];
   logic [DW-1:0] m_mem  [WORDS];
   bit            e_v    [MAXT];
   logic [DW-1:0] e_d    [MAXT];
   logic [DW-1:0] wds    [MAXT];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // starts and ends just after a falling edge
   task automatic load_entry(input int idx, input int addr, input bit wr);
      ld_en = 1'b1; ld_idx = SAW'(idx); ld_addr = AW'(addr); ld_wr = wr;
      @(negedge clk);
      ld_en = 1'b0;
      m_addr[idx] = AW'(addr);
      m_wr[idx]   = wr;
   endtask

   function automatic int run_total(input int len, input int reps);
      return len * (reps + 1);
   endfunction

   task automatic run_seq(input int start, input int len, input int reps, input bit inject);
      int total;
      total = run_total(len, reps);
      for (int k = 0; k < total; k++) begin
         int idx;
         idx    = (start + (k % len)) % DEPTH;
         wds[k] = DW'($urandom);
         e_v[k] = !m_wr[idx];
         e_d[k] = m_mem[m_addr[idx]];
         if (m_wr[idx]) m_mem[m_addr[idx]] = wds[k];
      end
      go = 1'b1; go_start = SAW'(start); go_len = (SAW+1)'(len); go_reps = RW'(reps);
      @(negedge clk);
      go = 1'b0;
      for (int c = 0; c <= total + 3; c++) begin
         bit inj_now;
         bit ev;
         inj_now = inject && (c == 1);
         // R7, R8: a refused load aims at an entry that later runs use; a late go is also injected
         ld_en = inj_now; ld_idx = SAW'(start); ld_addr = ~m_addr[start]; ld_wr = !m_wr[start];
         go = inj_now; go_start = SAW'(start + 3); go_len = (SAW+1)'(1); go_reps = '0;
         wdata = (c < total) ? wds[c] : DW'($urandom);
         chk(busy == (c < total), (reps > 0) ? "R9 busy" : "R5 busy", busy, c < total);
         chk(done == (c == total), "R6 done", done, c == total);
         chk(ld_err == (inject && c == 2), "R8 ld_err", ld_err, inject && c == 2);
         ev = (c >= 3) && (c - 3 < total) && e_v[c-3];
         chk(rvalid == ev, "R3 rvalid", rvalid, ev);
         if (ev) chk(rdata == e_d[c-3], "R4 rdata", rdata, e_d[c-3]);
         else    chk(rdata == '0, "R10 rdata idle", rdata, 0);
         @(negedge clk);
      end
      ld_en = 1'b0; go = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0 && rvalid == 0 && ld_err == 0, "R1 reset flags",
          {busy, done, rvalid, ld_err}, 0);
      chk(rdata == '0, "R1 reset rdata", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && rvalid == 0 && ld_err == 0, "R1 after reset",
          {busy, done, rvalid, ld_err}, 0);

      // R2 R4: fill the whole data array through two write programs
      for (int i = 0; i < DEPTH; i++) load_entry(i, i, 1'b1);
      run_seq(0, DEPTH, 0, 0);
      for (int i = 0; i < DEPTH; i++) load_entry(i, i + DEPTH, 1'b1);
      run_seq(0, DEPTH, 0, 0);

      // R2: random program with shared addresses (narrow range to force reuse)
      for (int i = 0; i < DEPTH; i++)
         load_entry(i, ($urandom % 2) ? int'($urandom % 8) : int'($urandom % WORDS), bit'($urandom % 2));
      for (int n = 0; n < 10; n++) begin
         int s, l, r;
         s = int'($urandom % DEPTH);
         l = 1 + int'($urandom % DEPTH);
         r = int'($urandom % 4);
         run_seq(s, l, r, run_total(l, r) >= 3 && (n % 2 == 0));
      end

      // R5: index wrap across the end of the table
      run_seq(DEPTH - 2, 5, 0, 1);
      // R9: single entry replayed back to back
      load_entry(7, 3, 1'b1);
      load_entry(8, 3, 1'b0);
      run_seq(7, 1, 3, 0);
      run_seq(7, 2, 2, 1);
      // R9: full table, two passes
      run_seq(0, DEPTH, 1, 1);

      // R7: zero-length start is ignored
      go = 1'b1; go_start = '0; go_len = '0; go_reps = RW'(2);
      @(negedge clk);
      go = 1'b0;
      chk(busy == 0, "R7 zero length", busy, 0);
      @(negedge clk);
      chk(done == 0 && busy == 0, "R7 zero length done", {busy, done}, 0);

      // R8: the refused loads left the table intact; rerun the affected entries
      run_seq(7, 2, 0, 0);
      run_seq(DEPTH - 2, 4, 1, 0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end
endmodule